// File: doc/BRIEF.md
# IPv4 Flow Tuple Hash Generator

This block turns an IPv4 flow tuple into a bucket index for a 4096-entry flow table. The tuple is the source address, the destination address, the source L4 port and the destination L4 port, all given with the most significant bit on the left. The block builds a 32-bit ports word and uses it as a bitwise select between the two addresses. It rotates that select result by one byte and XORs it with the ports word and both addresses. It then folds the 32-bit result to 11 bits and doubles it. The index that comes out is always even, so each hash names a pair of adjacent table slots that a lookup engine can probe in turn.

The hash is one register stage deep. A tuple presented with `tuple_valid_i` high produces `idx_o` and `idx_valid_o` on the next clock edge. When no valid tuple arrives, the last index stays on the output.

Top module: `flow_hash_v4`

## Requirements
- R1: The ports word is formed with the source port in bits 31:16 and the destination port in bits 15:0.
- R2: In the mix, operand A is the destination address and operand B is the source address. Swapping the two addresses at the inputs changes the index in general.
- R3: The select value is (ports AND A) OR ((NOT ports) AND B), taken bit by bit.
- R4: The select value is rotated left by 8 bits: bits 23:0 move to 31:8 and bits 31:24 move to 7:0.
- R5: The mixed word is ports XOR A XOR B XOR rotated select. It is folded as (mixed >> 16) XOR (mixed AND 0xFFFFF), and only the low 11 bits of the fold are kept.
- R6: `idx_o` is 12 bits wide and equals the 11-bit hash times two, so bit 0 is always 0.
- R7: `idx_valid_o` is high in the cycle after a clock edge at which `tuple_valid_i` was high, and low after an edge at which it was low. `idx_o` at that point belongs to the tuple that was sampled.
- R8: While `rst_ni` is low, `idx_o` is 0 and `idx_valid_o` is 0.
- R9: A clock edge with `tuple_valid_i` low leaves `idx_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tuple_valid_i | input | 1 | Tuple on the inputs is valid this cycle |
| src_ip_i | input | 32 | Source IPv4 address |
| dst_ip_i | input | 32 | Destination IPv4 address |
| src_port_i | input | 16 | Source L4 port |
| dst_port_i | input | 16 | Destination L4 port |
| idx_valid_o | output | 1 | Index valid, one cycle after a valid tuple |
| idx_o | output | 12 | Even table index (11-bit hash doubled) |

## Verification
Some properties are checked on every cycle by assertions:
- the valid flag tracks the input strobe with one cycle of delay;
- the index keeps its value across idle edges;
- the index is even whenever it is valid.

Other behaviour can only be shown by the bench's scenarios. These include the exact arithmetic of the mix: port placement, the address swap, the select polarity, the rotate direction and the fold. The scoreboard covers them by comparing each result with an independent model, using directed tuples and over a thousand random tuples with gaps in the valid strobe. The reset clear mid-run is also shown by a scenario.

// File: rtl/fh_pkg.sv
package fh_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned PORT_W = 16;
  parameter int unsigned HASH_W = 11;
  parameter int unsigned ROT_B  = 8;
  parameter int unsigned FOLD_SH = 16;
  parameter int unsigned FOLD_MW = 20;
  localparam int unsigned IDX_W = HASH_W + 1;

  typedef logic [ADDR_W-1:0] word_t;
  typedef logic [HASH_W-1:0] hash_t;
  typedef logic [IDX_W-1:0]  idx_t;
endpackage

// File: rtl/fh_mix.sv
module fh_mix
  import fh_pkg::*;
(
  input  logic [PORT_W-1:0] sport_i,
  input  logic [PORT_W-1:0] dport_i,
  input  word_t             opa_i,   // destination address
  input  word_t             opb_i,   // source address
  output word_t             mix_o
);
  word_t ports, sel, rot;

  assign ports = {sport_i, dport_i};
  assign sel   = (ports & opa_i) | (~ports & opb_i);

  // byte rotate left, built bit by bit
  for (genvar i = 0; i < ADDR_W; i++) begin : g_rot
    assign rot[(i + ROT_B) % ADDR_W] = sel[i];
  end

  assign mix_o = ports ^ opa_i ^ opb_i ^ rot;
endmodule

// File: rtl/fh_fold.sv
module fh_fold
  import fh_pkg::*;
(
  input  word_t mix_i,
  output idx_t  idx_o
);
  localparam word_t LOW_MASK = word_t'((64'd1 << FOLD_MW) - 64'd1);

  word_t folded;
  hash_t hash;

  assign folded = (mix_i >> FOLD_SH) ^ (mix_i & LOW_MASK);
  assign hash   = folded[HASH_W-1:0];
  assign idx_o  = {hash, 1'b0};
endmodule

// File: rtl/flow_hash_v4.sv
module flow_hash_v4
  import fh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tuple_valid_i,
  input  logic [ADDR_W-1:0] src_ip_i,
  input  logic [ADDR_W-1:0] dst_ip_i,
  input  logic [PORT_W-1:0] src_port_i,
  input  logic [PORT_W-1:0] dst_port_i,
  output logic              idx_valid_o,
  output logic [IDX_W-1:0]  idx_o
);
  word_t mix;
  idx_t  idx_d;

  // operands deliberately crossed: A = destination, B = source
  fh_mix u_mix (
    .sport_i (src_port_i),
    .dport_i (dst_port_i),
    .opa_i   (dst_ip_i),
    .opb_i   (src_ip_i),
    .mix_o   (mix)
  );

  fh_fold u_fold (
    .mix_i (mix),
    .idx_o (idx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_valid_o <= 1'b0;
      idx_o       <= '0;
    end else begin
      idx_valid_o <= tuple_valid_i;
      if (tuple_valid_i) idx_o <= idx_d;
    end
  end

  p_valid_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tuple_valid_i |=> idx_valid_o);
  p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tuple_valid_i |=> !idx_valid_o);
  p_idx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tuple_valid_i |=> $stable(idx_o));
  p_idx_even_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_valid_o |-> (idx_o[0] == 1'b0));
endmodule

// File: tb/sim_flow_hash_v4.sv
module sim_flow_hash_v4;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          v;
    logic [11:0] idx;
    int          stamp;
    string       tag;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        vld = 0;
  logic [31:0] sip = 0, dip = 0;
  logic [15:0] sp = 0, dp = 0;
  logic        ov;
  logic [11:0] oidx;

  int total = 0, bad = 0, cyc = 0;
  item_t q[$];
  logic [11:0] last_idx = 0;
  bit mon_en = 0;

  flow_hash_v4 u0 (
    .clk_i(clk), .rst_ni(rst_n), .tuple_valid_i(vld),
    .src_ip_i(sip), .dst_ip_i(dip), .src_port_i(sp), .dst_port_i(dp),
    .idx_valid_o(ov), .idx_o(oidx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] ref_idx(logic [31:0] s, logic [31:0] d,
                                          logic [15:0] ps, logic [15:0] pd);
    logic [31:0] pw, a, b, m, r, x, f;
    pw = (32'(ps) << 16) | 32'(pd);  // R1
    a  = d;                           // R2
    b  = s;
    m  = (pw & a) | (~pw & b);        // R3
    r  = (m << 8) | (m >> 24);        // R4
    x  = pw ^ a ^ b ^ r;              // R5
    f  = (x >> 16) ^ (x & 32'h000FFFFF);
    return 12'((f & 32'h7FF) * 2);    // R6
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, logic [31:0] s, logic [31:0] d,
                       logic [15:0] ps, logic [15:0] pd, string tag);
    item_t it;
    @(posedge clk); #1;
    vld = v; sip = s; dip = d; sp = ps; dp = pd;
    it.v = v; it.idx = ref_idx(s, d, ps, pd); it.stamp = cyc; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en && q.size() > 0 && q[0].stamp < cyc) begin
      item_t it;
      it = q.pop_front();
      check({it.tag, " R7 valid"}, 32'(ov), 32'(it.v));
      if (it.v) begin
        check({it.tag, " idx"}, 32'(oidx), 32'(it.idx));
        check({it.tag, " R6 even"}, 32'(oidx[0]), 32'd0);
        last_idx = it.idx;
      end else begin
        check({it.tag, " R9 hold"}, 32'(oidx), 32'(last_idx));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", 32'(ov), 0);
    check("R8 reset idx", 32'(oidx), 0);
    @(negedge clk); rst_n = 1; mon_en = 1;

    // directed: hand-computed and model-computed
    drive(1, 0, 0, 16'h0001, 16'h0000, "R1 sport only");
    drive(1, 0, 0, 16'h0000, 16'h0000, "R5 zero");
    drive(1, 32'h12345678, 32'h9ABCDEF0, 16'h1F90, 16'h0050, "R2 fwd");
    drive(1, 32'h9ABCDEF0, 32'h12345678, 16'h1F90, 16'h0050, "R2 swapped");
    drive(1, 32'hFF000000, 32'h00FF0000, 16'hFFFF, 16'h0000, "R3 select hi");
    drive(1, 32'hFF000000, 32'h00FF0000, 16'h0000, 16'hFFFF, "R3 select lo");
    drive(1, 32'h0, 32'hAB000000, 16'h0, 16'h0, "R4 rotate top byte");
    drive(0, 32'hDEADBEEF, 32'h1, 16'h5, 16'h6, "R9 idle");
    drive(0, 32'h1, 32'h2, 16'h3, 16'h4, "R9 idle2");
    drive(1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 16'hFFFF, "R5 all ones");
    drive(1, 32'hC0A80001, 32'h08080808, 16'hC350, 16'h0035, "R7 back2back");
    drive(1, 32'h0A000001, 32'h0A000002, 16'h0016, 16'hD431, "R7 back2back2");

    // random tuples with gaps
    for (int i = 0; i < 1100; i++) begin
      drive(($urandom % 4) != 0, $urandom, $urandom, 16'($urandom), 16'($urandom),
            "R5 random");
    end
    drive(0, 0, 0, 0, 0, "R9 tail");
    repeat (3) @(negedge clk);
    check("R7 queue drained", 32'(q.size()), 0);

    // R8: mid-run reset clears outputs
    mon_en = 0;
    drive(1, 32'h11112222, 32'h33334444, 16'h5555, 16'h6666, "R8 pre");
    @(negedge clk); #1;
    vld = 0;
    rst_n = 0;
    #1;
    check("R8 midrun valid", 32'(ov), 0);
    check("R8 midrun idx", 32'(oidx), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule